// File: doc/BRIEF.md
# Audio Controller Interrupt Status Aggregator

This block gathers every interrupt source of a multi-stream audio bus controller into one global status word and drives a single interrupt line toward the host. It owns three kinds of sticky state. The first is a three-bit status field for each stream descriptor, set by single-cycle event pulses from that stream's DMA engine. The second is a per-codec state-change register. The third is the interrupt-control mask. The response-ring interrupt and overrun flags arrive as levels from the ring logic. The codec wake-enable mask also arrives as a level.

Software reaches the state through a small register port. The port has a write strobe, a word address and write data. Read data is registered and is always returned for the presented address. Status fields clear when software writes a one to them. A zero in a clear position leaves that bit alone. The global status word is recomputed from its sources every cycle. An event is raised at most once per clock. The interrupt output runs in one of two modes. In level mode it follows the enabled global bit. In message mode it gives a one-cycle pulse on each rising edge of that bit.

Top module: `irq_status_agg`

Address map (word addresses): 0 = interrupt control, 1 = global status, 2 = codec state-change, 3+i = status word of stream i.

## Requirements
- R1: After synchronous reset, the control register reads 0, every stream status word reads 0, the codec state-change register reads the value of `codec_present`, and `irq_out` is 0.
- R2: A pulse on `strm_set[3*i+k]` sets bit 26+k of stream i's status word in the following cycle. Global status bit i equals bit 26 (buffer completion) of stream i's word.
- R3: A write to a stream status word clears each of bits 28:26 that is 1 in the write data. Bits written with 0 are left unchanged.
- R4: A pulse on `codec_wake[c]` sets state-change bit c. A write to address 2 clears the bits written as 1. When a set and a clear of the same bit coincide, the set wins.
- R5: Global status bit 30 is 1 while `rsp_irq_flag` or `rsp_ovr_flag` is 1, or while any state-change bit is also set in `wake_en`.
- R6: Global status bit 31 is 1 exactly when a collected source bit (30 or 7:0) is also 1 in the control register.
- R7: In level mode (`irq_msg_mode`=0), `irq_out` equals, one cycle later, the AND of global status bit 31 and control bit 31.
- R8: In message mode, `irq_out` is a one-cycle pulse on each rising edge of that AND. It stays low while the AND stays high.
- R9: Writes to the global status address leave no lasting effect. Its value is always the one recomputed from the sources.
- R10: Only control bits 31, 30 and 7:0 are writable. All other control bits read 0.
- R11: `reg_rdata` presents, one cycle after an address is applied, the value of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_msg_mode | input | 1 | 1 = message pulse, 0 = level interrupt |
| rsp_irq_flag | input | 1 | Response-ring interrupt flag (level) |
| rsp_ovr_flag | input | 1 | Response-ring overrun flag (level) |
| codec_present | input | NCODEC | Codec addresses present; reset value of state-change register |
| codec_wake | input | NCODEC | State-change set pulses, one per codec |
| wake_en | input | NCODEC | Wake-enable mask for state-change bits |
| strm_set | input | 3*NSTREAM | Per-stream status set pulses; bit 3i is completion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt output (level or pulse) |

## Verification
The bound checker watches the reset quietness, the link from stream completion pulses into the global word, and the response-flag path into bit 30 on every cycle. It also watches the rule that an empty control mask keeps bit 31 low, the one-cycle level-mode following, and that a message pulse never lasts two cycles. Write-one-to-clear semantics, set-over-clear priority, the writable control mask, the ineffectiveness of writes to the global word, and the timing of pulses against a held level are only shown by the bench's read-back and interrupt scenarios.

// File: rtl/isa_pkg.sv
package isa_pkg;
  localparam int DW        = 32;
  localparam int GLOB_BIT  = 31;
  localparam int CTRL_BIT  = 30;
  localparam int STRM_LSB  = 26;
  localparam int STRM_W    = 3;
  localparam int A_CTL     = 0;
  localparam int A_GSTS    = 1;
  localparam int A_CODEC   = 2;
  localparam int A_STRM0   = 3;
endpackage

// File: rtl/isa_w1c_bank.sv
module isa_w1c_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= rst_val;
    else     q <= (q & ~clr_i) | set_i;  // a set in the same cycle beats a clear
  end
endmodule

// File: rtl/isa_irq_drive.sv
module isa_irq_drive (
  input  logic clk,
  input  logic rst,
  input  logic msg_mode,
  input  logic level,
  output logic irq
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d <= 1'b0;
      irq     <= 1'b0;
    end else begin
      level_d <= level;
      irq     <= msg_mode ? (level & ~level_d) : level;
    end
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import isa_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 4,
  parameter int AW      = $clog2(NSTREAM + A_STRM0)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  irq_msg_mode,
  input  logic                  rsp_irq_flag,
  input  logic                  rsp_ovr_flag,
  input  logic [NCODEC-1:0]     codec_present,
  input  logic [NCODEC-1:0]     codec_wake,
  input  logic [NCODEC-1:0]     wake_en,
  input  logic [3*NSTREAM-1:0]  strm_set,
  input  logic                  reg_wr,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic                  irq_out
);
  localparam logic [DW-1:0] CTL_MASK =
    (DW'(1) << GLOB_BIT) | (DW'(1) << CTRL_BIT) | ((DW'(1) << NSTREAM) - DW'(1));

  logic [DW-1:0]     ctl_q;
  logic [DW-1:0]     collected;
  logic [DW-1:0]     gsts;
  logic [NCODEC-1:0] codec_sts;
  logic [NCODEC-1:0] codec_clr;
  logic [STRM_W-1:0] strm_sts [NSTREAM];
  logic              ctrl_src;
  logic              irq_level;
  logic [DW-1:0]     rd_mux;

  // interrupt-control register
  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (reg_wr && reg_addr == AW'(A_CTL)) ctl_q <= reg_wdata & CTL_MASK;
  end

  // codec state-change register
  assign codec_clr = (reg_wr && reg_addr == AW'(A_CODEC)) ? reg_wdata[NCODEC-1:0] : '0;

  isa_w1c_bank #(.W(NCODEC)) u_codec (
    .clk(clk), .rst(rst), .rst_val(codec_present),
    .set_i(codec_wake), .clr_i(codec_clr), .q(codec_sts)
  );

  // per-stream status fields
  for (genvar i = 0; i < NSTREAM; i++) begin : g_strm
    logic [STRM_W-1:0] clr;
    assign clr = (reg_wr && reg_addr == AW'(A_STRM0 + i))
                 ? reg_wdata[STRM_LSB +: STRM_W] : '0;
    isa_w1c_bank #(.W(STRM_W)) u_bank (
      .clk(clk), .rst(rst), .rst_val('0),
      .set_i(strm_set[STRM_W*i +: STRM_W]), .clr_i(clr), .q(strm_sts[i])
    );
  end

  // global status word, recomputed every cycle
  assign ctrl_src = rsp_irq_flag | rsp_ovr_flag | (|(codec_sts & wake_en));

  always_comb begin
    collected = '0;
    for (int i = 0; i < NSTREAM; i++) collected[i] = strm_sts[i][0];
    collected[CTRL_BIT] = ctrl_src;
    gsts = collected;
    gsts[GLOB_BIT] = |(collected & ctl_q);
  end

  assign irq_level = gsts[GLOB_BIT] & ctl_q[GLOB_BIT];

  isa_irq_drive u_drv (
    .clk(clk), .rst(rst), .msg_mode(irq_msg_mode),
    .level(irq_level), .irq(irq_out)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(A_CTL))   rd_mux = ctl_q;
    if (reg_addr == AW'(A_GSTS))  rd_mux = gsts;
    if (reg_addr == AW'(A_CODEC)) rd_mux[NCODEC-1:0] = codec_sts;
    for (int i = 0; i < NSTREAM; i++)
      if (reg_addr == AW'(A_STRM0 + i)) rd_mux[STRM_LSB +: STRM_W] = strm_sts[i];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
  parameter int NSTREAM = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 irq_msg_mode,
  input logic                 rsp_irq_flag,
  input logic [3*NSTREAM-1:0] strm_set,
  input logic                 irq_out,
  input logic [31:0]          gsts,
  input logic [31:0]          ctl_q
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_out == 1'b0 && ctl_q == 32'h0));  // R1

  for (genvar k = 0; k < NSTREAM; k++) begin : g_done
    AST_DONE_TO_GLOBAL: assert property (@(posedge clk) disable iff (rst)
      strm_set[3*k] |=> gsts[k]);  // R2
  end

  AST_RSP_RAISES_CTRL: assert property (@(posedge clk) disable iff (rst)
    rsp_irq_flag |-> gsts[30]);  // R5

  AST_EMPTY_MASK_NO_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (ctl_q == 32'h0) |-> !gsts[31]);  // R6

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(!irq_msg_mode) |-> (irq_out == $past(gsts[31] & ctl_q[31])));  // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (irq_msg_mode && irq_out) |=> !irq_out);  // R8
endmodule

bind irq_status_agg irq_status_agg_chk #(.NSTREAM(NSTREAM)) u_chk (
  .clk(clk), .rst(rst), .irq_msg_mode(irq_msg_mode), .rsp_irq_flag(rsp_irq_flag),
  .strm_set(strm_set), .irq_out(irq_out), .gsts(gsts), .ctl_q(ctl_q)
);

// File: tb/sim_irq_status_agg.sv
`timescale 1ns/1ps
module sim_irq_status_agg;
  localparam int NSTREAM = 8;
  localparam int NCODEC  = 4;
  localparam int AW      = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 irq_msg_mode = 1'b0;
  logic                 rsp_irq_flag = 1'b0;
  logic                 rsp_ovr_flag = 1'b0;
  logic [NCODEC-1:0]    codec_present = 4'b0101;
  logic [NCODEC-1:0]    codec_wake = '0;
  logic [NCODEC-1:0]    wake_en = '0;
  logic [3*NSTREAM-1:0] strm_set = '0;
  logic                 reg_wr = 1'b0;
  logic [AW-1:0]        reg_addr = '0;
  logic [31:0]          reg_wdata = '0;
  logic [31:0]          reg_rdata;
  logic                 irq_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_v = 1'b0;
  logic        rd_v_d = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_status_agg #(.NSTREAM(NSTREAM), .NCODEC(NCODEC), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .irq_msg_mode(irq_msg_mode),
    .rsp_irq_flag(rsp_irq_flag), .rsp_ovr_flag(rsp_ovr_flag),
    .codec_present(codec_present), .codec_wake(codec_wake), .wake_en(wake_en),
    .strm_set(strm_set), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // monitor: one cycle after a read request, compare against the queue head
  always @(posedge clk) rd_v_d <= rd_v;

  always @(negedge clk) begin
    if (rd_v_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %08h expected %08h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = AW'(a);
    rd_v = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_v = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s: irq_out actual %0b expected %0b", t, irq_out, e);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(0, 32'h0, "R1 ctl reset");
    rd(2, 32'h5, "R1 codec sts = present");
    rd(3, 32'h0, "R1 stream0 reset");
    rd(1, 32'h0, "R11 global read path");

    // R10 writable control mask
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'hC000_00FF, "R10 ctl mask");
    wr(0, 32'h0);

    // R2 stream events
    @(negedge clk); strm_set[9] = 1'b1;
    @(negedge clk); strm_set[9] = 1'b0;
    rd(6, 32'h0400_0000, "R2 stream3 completion");
    rd(1, 32'h0000_0008, "R2 global bit3");
    @(negedge clk); strm_set[17] = 1'b1;
    @(negedge clk); strm_set[17] = 1'b0;
    rd(8, 32'h1000_0000, "R2 stream5 bit28");
    rd(1, 32'h0000_0008, "R2 non-completion bit not in global");

    // R6 / R7
    wr(0, 32'h0000_0008);
    rd(1, 32'h8000_0008, "R6 global bit31");
    chk_irq(1'b0, "R7 no enable");
    wr(0, 32'h8000_0008);
    @(negedge clk);
    chk_irq(1'b1, "R7 level asserted");

    // R9 global status not writable
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h8000_0008, "R9 global after write");

    // R3 write-one-to-clear
    wr(6, 32'h0);
    rd(6, 32'h0400_0000, "R3 zero write keeps");
    wr(6, 32'h0800_0000);
    rd(6, 32'h0400_0000, "R3 other bit write keeps");
    wr(8, 32'h0400_0000);
    rd(8, 32'h1000_0000, "R3 stream5 bit28 kept");
    wr(6, 32'h0400_0000);
    rd(6, 32'h0, "R3 cleared");
    rd(1, 32'h0, "R3 global follows clear");
    chk_irq(1'b0, "R7 level drops");

    // R4 codec state-change
    wr(2, 32'h1);
    rd(2, 32'h4, "R4 clear bit0");
    @(negedge clk); codec_wake = 4'b0010;
    @(negedge clk); codec_wake = 4'b0000;
    rd(2, 32'h6, "R4 wake sets bit1");
    @(negedge clk);
    codec_wake = 4'b0010; reg_wr = 1'b1; reg_addr = AW'(2); reg_wdata = 32'h2;
    @(negedge clk);
    codec_wake = 4'b0000; reg_wr = 1'b0;
    rd(2, 32'h6, "R4 set beats clear");

    // R5 controller-level bit
    wake_en = 4'b1000;
    rd(1, 32'h0, "R5 masked state change");
    wake_en = 4'b0100;
    rd(1, 32'h4000_0000, "R5 enabled state change");
    wake_en = 4'b0000; rsp_ovr_flag = 1'b1;
    rd(1, 32'h4000_0000, "R5 overrun flag");
    rsp_ovr_flag = 1'b0;
    rd(1, 32'h0, "R5 sources quiet");

    // R7 level then R8 message mode
    wr(0, 32'hC000_0000);
    rsp_irq_flag = 1'b1;
    @(negedge clk); chk_irq(1'b1, "R7 level from response flag");
    rsp_irq_flag = 1'b0;
    @(negedge clk); chk_irq(1'b0, "R7 level released");
    irq_msg_mode = 1'b1;
    repeat (2) @(negedge clk);
    rsp_irq_flag = 1'b1;
    @(negedge clk); chk_irq(1'b1, "R8 pulse");
    @(negedge clk); chk_irq(1'b0, "R8 pulse single cycle");
    @(negedge clk); chk_irq(1'b0, "R8 held level no repeat");
    rsp_irq_flag = 1'b0;
    repeat (2) @(negedge clk);
    rsp_irq_flag = 1'b1;
    @(negedge clk); chk_irq(1'b1, "R8 second rising edge");
    rsp_irq_flag = 1'b0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule